// File: doc/BRIEF.md
# Processor Interrupt Level Arbiter

This block picks the most urgent pending interrupt level for a processor that masks interrupts by a current priority level. Each clock it merges the external level lines with the software interrupt register. Both timer bits of that register are folded onto level 14. It then finds the highest set level above the current processor level and posts a hard interrupt request together with a 9-bit trap type for that level.

A vectored interrupt in progress outranks every level interrupt, so while the busy flag is high the posted request is frozen. The request is also held back when the processor is already servicing a more urgent external-level trap at a nonzero trap level. Clearing the global enable, or masking every pending level, withdraws the request and zeroes the trap type. Results are registered, with a one-cycle strobe each time a new nonzero trap type is posted.

Top module: `pil_arbiter`

## Requirements
- R1: The pending vector is the OR of `ext_lvl[15:0]` and the level bits `soft_int[15:1]`. Bit 0 of `soft_int` (tick timer) and bit 16 (system timer) are not levels in their own right.
- R2: If `soft_int[0]` or `soft_int[16]` is set, level 14 counts as pending.
- R3: While `vec_busy` is high, `irq_req` and `irq_tt` keep their values whatever the other inputs do.
- R4: If no pending level is strictly greater than `cur_pil`, the next state has `irq_req`=0 and `irq_tt`=0. This covers `cur_pil`=15 and a request on level 0 alone.
- R5: With `int_en`=1, the winner is the highest pending level L with L > `cur_pil`. The posted values are `irq_req`=1 and `irq_tt`=0x040+L, which lies in 0x041..0x04F.
- R6: A new post is withheld, and both outputs keep their values, when `trap_lvl`≠0, `cur_tt` lies in 0x040..0x04F (bits 8:4 equal 4) and `cur_tt` is greater than the new trap type.
- R7: With `int_en`=0 and `vec_busy`=0, the next state has `irq_req`=0 and `irq_tt`=0.
- R8: Outputs are registered. Inputs sampled at one rising edge are reflected right after it. A synchronous active-high `rst` clears all outputs.
- R9: `tt_new` is high for exactly the cycle in which `irq_tt` takes a value that is nonzero and differs from its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_lvl | input | 16 | External level interrupt lines, bit i = level i |
| soft_int | input | 17 | Software interrupt register: [0] tick timer, [15:1] levels, [16] system timer |
| cur_pil | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap level |
| cur_tt | input | 9 | Trap type of the trap being serviced |
| vec_busy | input | 1 | Vectored interrupt pending |
| irq_req | output | 1 | Hard interrupt request |
| irq_tt | output | 9 | Trap type of the posted level, 0 when none |
| tt_new | output | 1 | One-cycle strobe on a new nonzero trap type |

## Verification
Single-hot external lines are swept over every level against every mask level. This separates "strictly above the mask" from "at or above" and exposes any bit that is mis-indexed. All-ones and pseudo-random multi-bit vectors test that the highest level wins over lower ones. Sweeps of software level bits and of each timer bit alone tell the software path and the level-14 folding apart from the external path. Targeted sequences around the busy flag, the enable and the in-service trap type check the hold-versus-clear choices, including trap types just inside and just outside the external group.

// File: rtl/pil_arb_pkg.sv
package pil_arb_pkg;
  localparam int TT_W = 9;
  localparam logic [TT_W-1:0] TT_EXT_BASE = 9'h040;
  localparam logic [4:0] EXT_GROUP = 5'h04;

  typedef struct packed {
    logic            req;
    logic [TT_W-1:0] tt;
  } post_t;
endpackage

// File: rtl/pil_pend_former.sv
module pil_pend_former #(
  parameter int NLVL      = 16,
  parameter int TIMER_LVL = 14
) (
  input  logic [NLVL-1:0] ext_lvl,
  input  logic [NLVL:0]   soft_int,
  output logic [NLVL-1:0] pend
);
  logic timer_hit;
  assign timer_hit = soft_int[0] | soft_int[NLVL];

  always_comb begin
    pend = ext_lvl | {soft_int[NLVL-1:1], 1'b0};
    if (timer_hit) pend[TIMER_LVL] = 1'b1;
  end
endmodule

// File: rtl/pil_level_pick.sv
module pil_level_pick #(
  parameter int NLVL  = 16,
  localparam int LVL_W = $clog2(NLVL)
) (
  input  logic [NLVL-1:0]  pend,
  input  logic [LVL_W-1:0] cur_pil,
  output logic             any_above,
  output logic [LVL_W-1:0] win
);
  logic [NLVL-1:0] above;
  logic [NLVL-1:0] cand;

  for (genvar g = 0; g < NLVL; g++) begin : g_above
    assign above[g] = (g > int'(cur_pil));
  end

  assign cand      = pend & above;
  assign any_above = |cand;

  always_comb begin
    win = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (cand[i]) win = LVL_W'(i);
    end
  end
endmodule

// File: rtl/pil_arbiter.sv
module pil_arbiter
  import pil_arb_pkg::*;
#(
  parameter int NLVL      = 16,
  parameter int TIMER_LVL = 14,
  parameter int TL_W      = 3,
  localparam int LVL_W    = $clog2(NLVL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NLVL-1:0]  ext_lvl,
  input  logic [NLVL:0]    soft_int,
  input  logic [LVL_W-1:0] cur_pil,
  input  logic             int_en,
  input  logic [TL_W-1:0]  trap_lvl,
  input  logic [TT_W-1:0]  cur_tt,
  input  logic             vec_busy,
  output logic             irq_req,
  output logic [TT_W-1:0]  irq_tt,
  output logic             tt_new
);
  logic [NLVL-1:0]  pend;
  logic             any_above;
  logic [LVL_W-1:0] win;
  logic [TT_W-1:0]  cand_tt;
  logic             blocked;
  post_t            st_q, st_d;
  logic             strobe_q;

  pil_pend_former #(.NLVL(NLVL), .TIMER_LVL(TIMER_LVL)) pend_i (
    .ext_lvl (ext_lvl),
    .soft_int(soft_int),
    .pend    (pend)
  );

  pil_level_pick #(.NLVL(NLVL)) pick_i (
    .pend     (pend),
    .cur_pil  (cur_pil),
    .any_above(any_above),
    .win      (win)
  );

  assign cand_tt = TT_EXT_BASE | TT_W'(win);
  assign blocked = (trap_lvl != '0) && (cur_tt[8:4] == EXT_GROUP) && (cur_tt > cand_tt);

  always_comb begin
    st_d = st_q;
    if (vec_busy) begin
      st_d = st_q;
    end else if (!any_above || !int_en) begin
      st_d = '{req: 1'b0, tt: '0};
    end else if (!blocked) begin
      st_d = '{req: 1'b1, tt: cand_tt};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= '{req: 1'b0, tt: '0};
      strobe_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      strobe_q <= (st_d.tt != st_q.tt) && (st_d.tt != '0);
    end
  end

  assign irq_req = st_q.req;
  assign irq_tt  = st_q.tt;
  assign tt_new  = strobe_q;
endmodule

// File: rtl/pil_arbiter_chk.sv
module pil_arbiter_chk #(
  parameter int NLVL = 16,
  parameter int TL_W = 3,
  localparam int LVL_W = $clog2(NLVL)
) (
  input logic             clk,
  input logic             rst,
  input logic [NLVL-1:0]  ext_lvl,
  input logic [NLVL:0]    soft_int,
  input logic             int_en,
  input logic             vec_busy,
  input logic             irq_req,
  input logic [8:0]       irq_tt,
  input logic             tt_new
);
  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (rst)
    vec_busy |=> ($stable(irq_req) && $stable(irq_tt)));

  assert_none_pending_R4: assert property (@(posedge clk) disable iff (rst)
    (!vec_busy && ext_lvl == '0 && soft_int == '0) |=> (!irq_req && irq_tt == '0));

  assert_tt_range_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_tt != '0) |-> (irq_tt[8:4] == 5'h04 && irq_tt[3:0] != 4'h0));

  assert_disabled_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (!vec_busy && !int_en) |=> (!irq_req && irq_tt == '0));

  assert_req_matches_tt_R8: assert property (@(posedge clk) disable iff (rst)
    irq_req == (irq_tt != '0));

  assert_strobe_change_R9: assert property (@(posedge clk) disable iff (rst)
    tt_new |-> (irq_tt != '0 && irq_tt != $past(irq_tt)));
endmodule

bind pil_arbiter pil_arbiter_chk #(.NLVL(NLVL), .TL_W(TL_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .ext_lvl (ext_lvl),
  .soft_int(soft_int),
  .int_en  (int_en),
  .vec_busy(vec_busy),
  .irq_req (irq_req),
  .irq_tt  (irq_tt),
  .tt_new  (tt_new)
);

// File: tb/pil_arbiter_tb.sv
module pil_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] ext_lvl;
  logic [16:0] soft_int;
  logic [3:0]  cur_pil;
  logic        int_en;
  logic [2:0]  trap_lvl;
  logic [8:0]  cur_tt;
  logic        vec_busy;
  logic        irq_req;
  logic [8:0]  irq_tt;
  logic        tt_new;

  int errors = 0;
  int checks = 0;
  logic       m_req;
  logic [8:0] m_tt;
  logic       m_str;
  logic       done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pil_arbiter dut_i (
    .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .soft_int(soft_int),
    .cur_pil(cur_pil), .int_en(int_en), .trap_lvl(trap_lvl), .cur_tt(cur_tt),
    .vec_busy(vec_busy), .irq_req(irq_req), .irq_tt(irq_tt), .tt_new(tt_new)
  );

  task automatic check(string tag);
    checks++;
    if (irq_req !== m_req || irq_tt !== m_tt || tt_new !== m_str) begin
      errors++;
      $display("FAIL %s: got req=%0b tt=%03h new=%0b, expected req=%0b tt=%03h new=%0b",
               tag, irq_req, irq_tt, tt_new, m_req, m_tt, m_str);
    end
  endtask

  // One clock step: drive after a falling edge, let one rising edge register, check at the next falling edge.
  task automatic step(input logic [15:0] e, input logic [16:0] s, input logic [3:0] p,
                      input logic en, input logic [2:0] tl, input logic [8:0] ctt,
                      input logic vb, input string tag);
    logic [15:0] pv;
    logic [8:0]  ntt;
    logic        nreq;
    int          lvl;
    ext_lvl = e; soft_int = s; cur_pil = p; int_en = en;
    trap_lvl = tl; cur_tt = ctt; vec_busy = vb;
    pv = e | {s[15:1], 1'b0};
    if (s[0] || s[16]) pv[14] = 1'b1;
    lvl = -1;
    for (int l = 15; l > int'(p); l--) begin
      if (pv[l] && lvl < 0) lvl = l;
    end
    nreq = m_req; ntt = m_tt;
    if (!vb) begin
      if (lvl < 0 || !en) begin
        nreq = 1'b0; ntt = 9'h000;
      end else if (!(tl != 0 && ctt >= 9'h040 && ctt <= 9'h04f && ctt > 9'(64 + lvl))) begin
        nreq = 1'b1; ntt = 9'(64 + lvl);
      end
    end
    m_str = (ntt != m_tt) && (ntt != 9'h000);
    m_req = nreq; m_tt = ntt;
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    rst = 1'b1; ext_lvl = '0; soft_int = '0; cur_pil = '0; int_en = 1'b0;
    trap_lvl = '0; cur_tt = '0; vec_busy = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    m_req = 1'b0; m_tt = 9'h000; m_str = 1'b0;
    check("R8 reset");
    rst = 1'b0;

    // R5 / R4: single-hot external level against every mask level
    for (int p = 0; p < 16; p++)
      for (int l = 0; l < 16; l++)
        step(16'(1) << l, '0, 4'(p), 1'b1, '0, '0, 1'b0, "R5 R4 single level");

    // R5: all-ones picks level 15 unless masked
    for (int p = 0; p < 16; p++)
      step(16'hffff, '0, 4'(p), 1'b1, '0, '0, 1'b0, "R5 all ones");

    // R1: software level bits alone
    for (int l = 1; l < 16; l++) begin
      step('0, 17'(1) << l, 4'd0, 1'b1, '0, '0, 1'b0, "R1 soft level");
      step('0, '0, 4'd0, 1'b1, '0, '0, 1'b0, "R4 idle");
    end

    // R2: timer bits fold onto level 14
    step('0, 17'h00001, 4'd0,  1'b1, '0, '0, 1'b0, "R2 tick timer");
    step('0, '0,        4'd0,  1'b1, '0, '0, 1'b0, "R4 idle");
    step('0, 17'h10000, 4'd13, 1'b1, '0, '0, 1'b0, "R2 system timer");
    step('0, 17'h10000, 4'd14, 1'b1, '0, '0, 1'b0, "R2 R4 timer masked");
    step(16'h0001, 17'h00000, 4'd0, 1'b1, '0, '0, 1'b0, "R4 level zero only");

    // R3: busy flag freezes the outputs
    step(16'h0020, '0, 4'd0, 1'b1, '0, '0, 1'b0, "R5 post 0x45");
    step(16'hffff, '0, 4'd0, 1'b1, '0, '0, 1'b1, "R3 busy higher level");
    step(16'h0000, '0, 4'd0, 1'b0, '0, '0, 1'b1, "R3 busy disabled");
    step(16'h0000, '0, 4'd15, 1'b1, '0, '0, 1'b1, "R3 busy masked");
    step(16'hffff, '0, 4'd0, 1'b1, '0, '0, 1'b0, "R3 release");

    // R6: in-service external trap suppression
    step(16'h0002, '0, 4'd0, 1'b1, '0, '0, 1'b0, "R5 post 0x41");
    step(16'h2000, '0, 4'd0, 1'b1, 3'd1, 9'h04e, 1'b0, "R6 suppressed lower");
    step(16'h8000, '0, 4'd0, 1'b1, 3'd1, 9'h04e, 1'b0, "R6 higher posts");
    step(16'h2000, '0, 4'd0, 1'b1, 3'd0, 9'h04e, 1'b0, "R6 trap level zero");
    step(16'h0004, '0, 4'd0, 1'b1, 3'd2, 9'h03e, 1'b0, "R6 outside group");
    step(16'h0004, '0, 4'd0, 1'b1, 3'd2, 9'h050, 1'b0, "R6 above group");
    step(16'h0008, '0, 4'd0, 1'b1, 3'd2, 9'h043, 1'b0, "R6 equal type");
    step(16'h0002, '0, 4'd0, 1'b1, 3'd7, 9'h04f, 1'b0, "R6 suppressed deep");

    // R7: disable withdraws the request
    step(16'hffff, 17'h1ffff, 4'd0, 1'b0, '0, '0, 1'b0, "R7 disabled");
    step(16'h0400, '0, 4'd0, 1'b1, '0, '0, 1'b0, "R9 new post");
    step(16'h0400, '0, 4'd0, 1'b1, '0, '0, 1'b0, "R9 same post no strobe");

    // R1-style mixed pseudo-random patterns covering R5 R6 R3 R7 R9
    lf = 32'h1ace_b00c;
    for (int k = 0; k < 3000; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step(lf[15:0] & {16{lf[27]}}, {lf[31], lf[18:3]} & {17{lf[26]}}, lf[23:20],
           lf[30] | lf[29], {lf[28], 2'b0} | {2'b0, lf[19]},
           {5'h04, lf[25:22]} ^ {lf[2], 8'h00}, lf[24] & lf[17], "R5 random mix");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule